// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running nanosecond count for precision timestamping. On each edge of its reference clock it adds a programmed base step, normally the reference period in nanoseconds (one billion divided by the clock frequency). Frequency is trimmed without a fractional accumulator. Once every programmed number of steps, an alternate step replaces the base step. Software makes the clock run fast by setting the alternate step above the base step, and slow by setting it below.

Software uses a small word-addressed register port. One register holds both step sizes: the base step and the alternate step. Another holds the trim interval. A third gives the live time and can be loaded directly with the wanted time taken modulo the counter width. A capture strobe freezes the live time into a snapshot register, so a multi-cycle software read sees one coherent value.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time and snapshot are 0, the trim interval is 0, the alternate step is 0, and the base step equals the parameter RESET_BASE (8 by default).
- R2: With a trim interval of 0 the time grows by exactly the base step on every clock edge.
- R3: With a trim interval N of 2 or more, every Nth edge adds the alternate step and the other edges add the base step. The alternate step may be above the base step (speed-up) or below it (slow-down).
- R4: With a trim interval of 1 every edge adds the alternate step.
- R5: Writing the trim interval (address 1) restarts the step count, so the first alternate step falls on the Nth edge after the write edge.
- R6: The step register (address 0) holds the base step in bits [6:0] and the alternate step in bits [14:8]. Its other bits read as 0 and ignore writes. New values take effect from the edge after the write.
- R7: Writing address 2 loads the written value into the time on the next edge, in place of that edge's step. The step count keeps advancing across the load.
- R8: The time wraps modulo 2^32.
- R9: A capture pulse makes the snapshot (address 3) take the time held just before that edge. Without a pulse the snapshot holds its value.
- R10: reg_rdata combinationally returns the register selected by reg_addr: 0 step, 1 trim interval, 2 live time, 3 snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| capture | input | 1 | Snapshot strobe |
| time_now | output | 32 | Live nanosecond time |

## Verification
The counter is first run with no trimming, then with intervals of 5, 1 and 4, using both a larger and a smaller alternate step. Comparing these runs separates off-by-one errors in the interval from errors in choosing the step. The bench rewrites the interval while the step count is partway through and loads the time while a trim is pending, which shows whether each write restarts the step count or leaves it alone. A load near 2^32 checks the wrap. A capture on the same edge as a load shows whether the snapshot takes the value from before or after that edge.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int DATA_W = 32;
  typedef enum logic [1:0] {
    SEL_STEP   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_TIME   = 2'd2,
    SEL_SNAP   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int STEP_W     = 7,
  parameter int ALT_LSB    = 8,
  parameter int PERIOD_W   = 16,
  parameter int TIME_W     = 32,
  parameter int RESET_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [TIME_W-1:0]   time_i,
  input  logic [TIME_W-1:0]   snap_i,
  output logic [STEP_W-1:0]   base_o,
  output logic [STEP_W-1:0]   alt_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                period_wr_o,
  output logic                time_wr_o,
  output logic [DATA_W-1:0]   rdata
);
  logic [STEP_W-1:0]   base_q, base_d, alt_q, alt_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic                step_en;

  assign step_en     = wr && (addr == SEL_STEP);
  assign period_wr_o = wr && (addr == SEL_PERIOD);
  assign time_wr_o   = wr && (addr == SEL_TIME);

  always_comb begin
    base_d   = base_q;
    alt_d    = alt_q;
    period_d = period_q;
    if (step_en) begin
      base_d = wdata[STEP_W-1:0];
      alt_d  = wdata[ALT_LSB +: STEP_W];
    end
    if (period_wr_o) period_d = wdata[PERIOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= STEP_W'(RESET_BASE);
      alt_q    <= '0;
      period_q <= '0;
    end else begin
      base_q   <= base_d;
      alt_q    <= alt_d;
      period_q <= period_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_sel_e'(addr))
      SEL_STEP: begin
        rdata[STEP_W-1:0]       = base_q;
        rdata[ALT_LSB +: STEP_W] = alt_q;
      end
      SEL_PERIOD: rdata = DATA_W'(period_q);
      SEL_TIME:   rdata = DATA_W'(time_i);
      default:    rdata = DATA_W'(snap_i);
    endcase
  end

  assign base_o   = base_q;
  assign alt_o    = alt_q;
  assign period_o = period_q;

  assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !step_en) |=> (base_q == $past(base_q) && alt_q == $past(alt_q)));
endmodule

// File: rtl/ptp_tc_step.sv
module ptp_tc_step #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                period_wr_i,
  output logic                use_alt_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                active;

  assign active    = (period_i != '0);
  assign use_alt_o = active && (cnt_q == period_i - PERIOD_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (period_wr_i || !active || use_alt_o) cnt_d = '0;
    else                                     cnt_d = cnt_q + PERIOD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < period_i));
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && period_wr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ptp_tc_time.sv
module ptp_tc_time #(
  parameter int TIME_W = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] base_i,
  input  logic [STEP_W-1:0] alt_i,
  input  logic              use_alt_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  input  logic              capture_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] snap_o
);
  logic [TIME_W-1:0] time_q, time_d, snap_q, snap_d;
  logic [STEP_W-1:0] step;

  assign step = use_alt_i ? alt_i : base_i;

  always_comb begin
    time_d = load_i ? load_val_i : time_q + TIME_W'(step);
    snap_d = capture_i ? time_q : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      snap_q <= '0;
    end else begin
      time_q <= time_d;
      snap_q <= snap_d;
    end
  end

  assign time_o = time_q;
  assign snap_o = snap_q;

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_i) |=> (time_q == $past(load_val_i)));
  assert_base_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load_i && !use_alt_i) |=> (time_q == $past(time_q) + TIME_W'($past(base_i))));
  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && capture_i) |=> (snap_q == $past(time_q)));
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !capture_i) |=> $stable(snap_q));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int STEP_W     = 7,
  parameter int ALT_LSB    = 8,
  parameter int PERIOD_W   = 16,
  parameter int RESET_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              capture,
  output logic [DATA_W-1:0] time_now
);
  localparam int TIME_W = DATA_W;

  logic [STEP_W-1:0]   base, alt;
  logic [PERIOD_W-1:0] period;
  logic                period_wr, time_wr, use_alt;
  logic [TIME_W-1:0]   time_q, snap_q;

  ptp_tc_regs #(
    .STEP_W(STEP_W), .ALT_LSB(ALT_LSB), .PERIOD_W(PERIOD_W),
    .TIME_W(TIME_W), .RESET_BASE(RESET_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .time_i(time_q), .snap_i(snap_q), .base_o(base), .alt_o(alt),
    .period_o(period), .period_wr_o(period_wr), .time_wr_o(time_wr),
    .rdata(reg_rdata)
  );

  ptp_tc_step #(.PERIOD_W(PERIOD_W)) u_step (
    .clk(clk), .rst_n(rst_n), .period_i(period), .period_wr_i(period_wr),
    .use_alt_o(use_alt)
  );

  ptp_tc_time #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_time (
    .clk(clk), .rst_n(rst_n), .base_i(base), .alt_i(alt), .use_alt_i(use_alt),
    .load_i(time_wr), .load_val_i(reg_wdata), .capture_i(capture),
    .time_o(time_q), .snap_o(snap_q)
  );

  assign time_now = time_q;

  assert_every_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !reg_wr && period == PERIOD_W'(1)) |=>
      (time_q == $past(time_q) + TIME_W'($past(alt))));
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        capture = 1'b0;
  logic [31:0] time_now;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  logic [31:0] m_time = '0, m_snap = '0;
  int unsigned m_base = 8, m_alt = 0, m_period = 0, m_cnt = 0;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .capture(capture),
    .time_now(time_now)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return 32'((m_alt << 8) | m_base);
      2'd1: return 32'(m_period);
      2'd2: return m_time;
      default: return m_snap;
    endcase
  endfunction

  // Reference model: updated on each edge, compared a quarter period later.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_time = '0; m_snap = '0; m_base = 8; m_alt = 0; m_period = 0; m_cnt = 0;
    end else begin
      bit fire;
      int unsigned stp;
      fire = (m_period != 0) && (m_cnt + 1 == m_period);
      stp  = fire ? m_alt : m_base;
      if (capture) m_snap = m_time;
      if (reg_wr && reg_addr == 2'd2) m_time = reg_wdata;
      else                            m_time = m_time + 32'(stp);
      if (reg_wr && reg_addr == 2'd1)    m_cnt = 0;
      else if (m_period == 0 || fire)    m_cnt = 0;
      else                               m_cnt = m_cnt + 1;
      if (reg_wr && reg_addr == 2'd0) begin
        m_base = int'(reg_wdata[6:0]);
        m_alt  = int'(reg_wdata[14:8]);
      end
      if (reg_wr && reg_addr == 2'd1) m_period = int'(reg_wdata[15:0]);
    end
    #(CLK_P/4);
    if (cmp_on && rst_n) begin
      check(phase, time_now, m_time);
      check({phase, "/R10"}, reg_rdata, m_read(reg_addr));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic peek(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R1: reset state seen while reset is held and right after release
    peek("R1", 2'd0, 32'h0000_0008);
    peek("R1", 2'd1, 32'h0);
    peek("R1", 2'd2, 32'h0);
    peek("R1", 2'd3, 32'h0);
    rst_n = 1'b1;
    reg_addr = 2'd2;
    cmp_on = 1'b1;

    phase = "R2"; cyc(20);

    // R6: bits outside both fields are dropped
    phase = "R6";
    wreg(2'd0, 32'hFFFF_8B08);
    peek("R6", 2'd0, 32'h0000_0B08);
    cyc(2);

    // R3: speed-up with interval 5, then slow-down
    phase = "R3";
    wreg(2'd1, 32'd5); cyc(30);
    wreg(2'd0, 32'h0000_0508); cyc(25);

    // R4: every step is the alternate step
    phase = "R4";
    wreg(2'd0, 32'h0000_0C08);
    wreg(2'd1, 32'd1); cyc(10);

    // R5: rewrite the interval partway through a count
    phase = "R5";
    wreg(2'd1, 32'd7); cyc(3);
    wreg(2'd1, 32'd4); cyc(12);
    wreg(2'd1, 32'd4); cyc(2);
    wreg(2'd1, 32'd4); cyc(9);

    // R7: load while a trim is pending, count continues across the load
    phase = "R7";
    cyc(2);
    wreg(2'd2, 32'h1234_5600); cyc(6);
    wreg(2'd2, 32'h0000_0100); cyc(6);

    // R9: capture, including a capture on the same edge as a load
    phase = "R9";
    @(negedge clk); capture = 1'b1;
    @(negedge clk); capture = 1'b0;
    cyc(4);
    peek("R9", 2'd3, m_snap);
    @(negedge clk);
    capture = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'hAAAA_0000;
    @(negedge clk);
    capture = 1'b0; reg_wr = 1'b0; reg_addr = 2'd3;
    cyc(5);

    // R8: wrap past 2^32 with base step 8, no trimming
    phase = "R8";
    wreg(2'd1, 32'd0);
    wreg(2'd0, 32'h0000_0008);
    wreg(2'd2, 32'hFFFF_FFF0);
    cyc(2);
    check("R8", time_now, 32'h0000_0000);
    cyc(6);

    phase = "R10";
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); reg_addr = 2'(a);
    end
    cyc(2);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule